// File: doc/BRIEF.md
# Serial Character Transmitter with Break and Out-of-Band Insertion

This block turns a ready/valid stream of bytes into an asynchronous serial line. Each character goes out as one start bit, eight data bits least significant first, an optional parity bit and one stop bit. Every bit lasts one period of the `baud_tick` strobe. The parity bit can be odd, even, stuck at 0 or stuck at 1. A stream item is accepted only on a baud tick when the line is free, so characters follow each other with no gap while `in_valid` stays high.

Two commands sit beside the stream. A pulse on `ins_req` captures `ins_char` and sends it as soon as the character now on the line has finished, ahead of any queued stream item. This is used for flow-control bytes such as XON and XOFF. A pulse on `abort_req` during a character cuts that character off at once and drives a break, a low line for a programmed number of character times. The line is then held high for one bit period before the transmitter goes back to idle.

The controller has seven states. IDLE moves to START when an item loads. START, DATA, PAR and STOP each advance on a tick: DATA moves to PAR when parity is on and to STOP when it is off. STOP moves to START if a new item loads on that tick, and to IDLE if none does. Each of START, DATA, PAR and STOP moves to BREAK when an abort arrives. BREAK moves to MARK when its count runs out, and MARK moves to IDLE on the next tick.

Top module: `uart_tx_ctl`

## Requirements
- R1: After reset `tx_line` is 1, `busy` is 0 and `in_ready` is 0 until a baud tick arrives.
- R2: A character is a 0 start bit, then 8 data bits least significant first, then a 1 stop bit. Each bit lasts exactly one tick-to-tick period. When `par_en` is 0, no parity bit is sent.
- R3: When `par_en` is 1, one parity bit follows the data. `par_mode` selects it: 2'b00 gives odd parity, 2'b01 gives a constant 0, 2'b10 gives even parity and 2'b11 gives a constant 1.
- R4: `in_ready` is high only during a baud-tick cycle in IDLE, or in STOP with no pending insert. With `in_valid` held, the next start bit directly follows the previous stop bit, so accepts are exactly one frame length apart.
- R5: An insert requested while idle is sent, starting at the next baud tick.
- R6: An insert requested during a character is sent right after that character, before the next stream item.
- R7: A second insert request made while a previous one is still unsent is ignored.
- R8: An abort in any cycle of START, DATA, PAR or STOP drives `tx_line` to 0 on the next clock. The cut-off character is dropped and is not sent again.
- R9: The break holds the line low for `brk_chars` × (10 + `par_en`) complete bit periods after the abort.
- R10: After the break, the line is 1 with `busy` high for one full bit period. The block then returns to idle.
- R11: An abort while idle has no effect: the line stays 1 and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted this cycle when valid |
| par_en | input | 1 | Append a parity bit |
| par_mode | input | 2 | Parity kind: 00 odd, 01 zero, 10 even, 11 one |
| abort_req | input | 1 | Abort strobe |
| ins_req | input | 1 | Insert strobe |
| ins_char | input | 8 | Out-of-band byte captured with `ins_req` |
| brk_chars | input | 4 | Break length in character times |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Transmitter not idle |

## Verification
Bytes 0x00, 0xFF, 0x01, 0x80 and 0xA5 are sent with parity off and then under each of the four parity modes. The all-zero and all-one bytes separate odd parity from even, and the single-bit bytes expose a reversed bit order. A held-valid burst checks that starts follow stops with no gap, and it would catch an extra idle bit or a lost accept. Insert requests are made while idle, in the middle of a character with a stream byte waiting, and twice in a row, which tells apart correct ordering, late insertion and a duplicate send. Aborts are made in the data phase with parity on and in the start bit with parity off. The two cases have different break lengths, so an off-by-one break count or a missing post-break mark shows up.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BREAK,
        ST_MARK
    } tx_state_e;

    typedef enum logic [1:0] {
        PM_ODD  = 2'b00,
        PM_ZERO = 2'b01,
        PM_EVEN = 2'b10,
        PM_ONE  = 2'b11
    } par_mode_e;
endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic [1:0]    mode,
    output logic          pbit
);
    import uart_tx_pkg::*;

    always_comb begin
        unique case (par_mode_e'(mode))
            PM_ODD:  pbit = ~^data;
            PM_ZERO: pbit = 1'b0;
            PM_EVEN: pbit = ^data;
            default: pbit = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_brk_cnt.sv
module uart_tx_brk_cnt #(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          tick,
    input  logic [CW-1:0] brk_chars,
    input  logic          par_en,
    output logic          done
);
    localparam int BASE = DW + 2;
    localparam int TW   = CW + $clog2(BASE + 2) + 1;

    logic [TW-1:0] cnt;
    logic [TW-1:0] chars_eff;
    logic [TW-1:0] frame_bits;

    assign chars_eff  = (brk_chars == '0) ? TW'(1) : TW'(brk_chars);
    assign frame_bits = TW'(BASE) + TW'(par_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= chars_eff * frame_bits;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/uart_tx_ctl.sv
module uart_tx_ctl #(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          par_en,
    input  logic [1:0]    par_mode,
    input  logic          abort_req,
    input  logic          ins_req,
    input  logic [DW-1:0] ins_char,
    input  logic [CW-1:0] brk_chars,
    output logic          tx_line,
    output logic          busy
);
    import uart_tx_pkg::*;

    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    tx_state_e     st, st_nxt;
    logic [DW-1:0] shreg;
    logic [IW-1:0] bit_idx;
    logic          cur_par;
    logic          cur_pen;
    logic          ins_pend;
    logic [DW-1:0] ins_hold;

    logic          in_frame;
    logic          abort_now;
    logic          can_load;
    logic          load_ins;
    logic          load_dat;
    logic [DW-1:0] load_byte;
    logic          load_pbit;
    logic          brk_done;

    assign in_frame  = (st == ST_START) || (st == ST_DATA) ||
                       (st == ST_PAR)   || (st == ST_STOP);
    assign abort_now = abort_req && in_frame;
    assign can_load  = baud_tick && !abort_now &&
                       ((st == ST_IDLE) || (st == ST_STOP));
    assign load_ins  = can_load && ins_pend;
    assign in_ready  = can_load && !ins_pend;
    assign load_dat  = in_ready && in_valid;
    assign load_byte = load_ins ? ins_hold : in_data;

    uart_tx_parity #(.DW(DW)) u_par (
        .data (load_byte),
        .mode (par_mode),
        .pbit (load_pbit)
    );

    uart_tx_brk_cnt #(.DW(DW), .CW(CW)) u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (abort_now),
        .tick      (baud_tick),
        .brk_chars (brk_chars),
        .par_en    (par_en),
        .done      (brk_done)
    );

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (load_ins || load_dat) st_nxt = ST_START;
            ST_START: if (abort_now) st_nxt = ST_BREAK;
                      else if (baud_tick) st_nxt = ST_DATA;
            ST_DATA:  if (abort_now) st_nxt = ST_BREAK;
                      else if (baud_tick && bit_idx == IW'(DW - 1))
                          st_nxt = cur_pen ? ST_PAR : ST_STOP;
            ST_PAR:   if (abort_now) st_nxt = ST_BREAK;
                      else if (baud_tick) st_nxt = ST_STOP;
            ST_STOP:  if (abort_now) st_nxt = ST_BREAK;
                      else if (baud_tick)
                          st_nxt = (load_ins || load_dat) ? ST_START : ST_IDLE;
            ST_BREAK: if (baud_tick && brk_done) st_nxt = ST_MARK;
            ST_MARK:  if (baud_tick) st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            cur_par  <= 1'b0;
            cur_pen  <= 1'b0;
            ins_pend <= 1'b0;
            ins_hold <= '0;
        end else begin
            st <= st_nxt;
            if (load_ins || load_dat) begin
                shreg   <= load_byte;
                cur_par <= load_pbit;
                cur_pen <= par_en;
                bit_idx <= '0;
            end else if (st == ST_DATA && baud_tick && !abort_now) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + IW'(1);
            end
            if (abort_now) begin
                ins_pend <= 1'b0;
            end else if (ins_req && !ins_pend) begin
                ins_pend <= 1'b1;
                ins_hold <= ins_char;
            end else if (load_ins) begin
                ins_pend <= 1'b0;
            end
        end
    end

    always_comb begin
        busy = (st != ST_IDLE);
        unique case (st)
            ST_IDLE:  tx_line = 1'b1;
            ST_START: tx_line = 1'b0;
            ST_DATA:  tx_line = shreg[0];
            ST_PAR:   tx_line = cur_par;
            ST_STOP:  tx_line = 1'b1;
            ST_BREAK: tx_line = 1'b0;
            ST_MARK:  tx_line = 1'b1;
            default:  tx_line = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_ctl_chk.sv
module uart_tx_ctl_chk
    import uart_tx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      baud_tick,
    input logic      in_ready,
    input logic      abort_req,
    input logic      ins_req,
    input logic      tx_line,
    input logic      busy,
    input tx_state_e st,
    input logic      ins_pend,
    input logic [7:0] ins_hold
);
    logic framing;
    assign framing = (st == ST_START) || (st == ST_DATA) ||
                     (st == ST_PAR) || (st == ST_STOP);

    p_ready_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> baud_tick);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    p_abort_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (framing && abort_req) |=> !tx_line);

    p_ins_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_pend && ins_req && !baud_tick) |=> $stable(ins_hold) && ins_pend);

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && abort_req && !baud_tick) |=> !busy);

    p_mark_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_BREAK && st == ST_MARK) |-> (tx_line && busy));
endmodule

bind uart_tx_ctl uart_tx_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .in_ready  (in_ready),
    .abort_req (abort_req),
    .ins_req   (ins_req),
    .tx_line   (tx_line),
    .busy      (busy),
    .st        (st),
    .ins_pend  (ins_pend),
    .ins_hold  (ins_hold)
);

// File: tb/uart_tx_ctl_tb.sv
`timescale 1ns/1ps
module uart_tx_ctl_tb;
    localparam int DIV = 8;

    typedef struct {
        logic [7:0] data;
        logic       pen;
        logic       pbit;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       par_en = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       abort_req = 1'b0;
    logic       ins_req = 1'b0;
    logic [7:0] ins_char = '0;
    logic [3:0] brk_chars = 4'd1;
    logic       tx_line;
    logic       busy;

    int   errors = 0;
    int   checks = 0;
    bit   done = 0;
    bit   mon_en = 1;
    int   tick_cnt = 0;
    int   acc_tick = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    uart_tx_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .par_en(par_en), .par_mode(par_mode), .abort_req(abort_req),
        .ins_req(ins_req), .ins_char(ins_char), .brk_chars(brk_chars),
        .tx_line(tx_line), .busy(busy)
    );

    initial begin
        forever begin
            repeat (DIV - 1) @(negedge clk);
            baud_tick <= 1'b1;
            @(negedge clk);
            baud_tick <= 1'b0;
        end
    end

    always @(posedge clk) if (baud_tick) tick_cnt <= tick_cnt + 1;

    function automatic logic exp_par(logic [7:0] d, logic [1:0] m);
        case (m)
            2'b00:   return ~^d;
            2'b01:   return 1'b0;
            2'b10:   return ^d;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [7:0] d, string tag);
        exp_t e;
        e.data = d; e.pen = par_en; e.pbit = exp_par(d, par_mode); e.tag = tag;
        q.push_back(e);
    endtask

    task automatic send(logic [7:0] d, string tag);
        @(negedge clk);
        in_data = d;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        acc_tick = tick_cnt;
        push(d, tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic insert(logic [7:0] d, bit expect_sent, string tag);
        @(negedge clk);
        ins_char = d;
        ins_req = 1'b1;
        if (expect_sent) push(d, tag);
        @(negedge clk);
        ins_req = 1'b0;
    endtask

    task automatic wait_ticks(int n);
        repeat (n) @(posedge clk iff baud_tick);
    endtask

    task automatic sample_after_tick(output logic v);
        @(posedge clk iff baud_tick);
        @(negedge clk);
        v = tx_line;
    endtask

    task automatic drain;
        while (busy || q.size() != 0) @(negedge clk);
        wait_ticks(2);
    endtask

    // Scoreboard monitor: decodes frames at the line and compares with the queue
    initial begin
        logic       b;
        logic [7:0] d;
        exp_t       e;
        forever begin
            sample_after_tick(b);
            if (mon_en && !b) begin
                e.data = '0; e.pen = 1'b0; e.pbit = 1'b0; e.tag = "R2";
                if (q.size() != 0) e = q.pop_front();
                else check(0, "R6", "unexpected frame", 1, 0);
                for (int i = 0; i < 8; i++) begin
                    sample_after_tick(b);
                    d[i] = b;
                end
                check(d == e.data, e.tag, "data", d, e.data);
                if (e.pen) begin
                    sample_after_tick(b);
                    check(b == e.pbit, "R3", "parity", b, e.pbit);
                end
                sample_after_tick(b);
                check(b == 1'b1, "R2", "stop bit", b, 1);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] pat [5] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'hA5};
        logic b;
        int   lows;
        int   t0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx_line === 1'b1, "R1", "line at reset", tx_line, 1);
        check(busy === 1'b0, "R1", "busy at reset", busy, 0);
        check(in_ready === 1'b0, "R1", "ready at reset", in_ready, 0);
        rst_n = 1'b1;
        wait_ticks(2);

        // R2 frames without parity
        par_en = 1'b0;
        foreach (pat[i]) send(pat[i], "R2");
        drain();

        // R3 all parity modes
        par_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            par_mode = 2'(m);
            foreach (pat[i]) send(pat[i], "R3");
            drain();
        end

        // R4 back-to-back accepts one frame apart (11 bits with parity)
        send(8'h3C, "R4");
        t0 = acc_tick;
        send(8'hC3, "R4");
        check(acc_tick - t0 == 11, "R4", "accept spacing", acc_tick - t0, 11);
        t0 = acc_tick;
        send(8'h5A, "R4");
        check(acc_tick - t0 == 11, "R4", "accept spacing", acc_tick - t0, 11);
        drain();

        // R5 insert while idle
        par_en = 1'b0;
        insert(8'h11, 1, "R5");
        drain();

        // R6/R7 insert mid-character before queued byte, second insert ignored
        send(8'h41, "R6");
        fork
            send(8'h42, "R6");
        join_none
        wait_ticks(3);
        insert(8'h13, 1, "R6");
        wait_ticks(1);
        insert(8'h77, 0, "R7");
        #1;
        drain();
        check(q.size() == 0, "R7", "queue empty", q.size(), 0);

        // R8/R9/R10 abort in data phase, parity on, 2 chars -> 22 bits
        mon_en = 0;
        par_en = 1'b1;
        brk_chars = 4'd2;
        send(8'hE7, "R8");
        wait_ticks(4);
        @(negedge clk);
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        check(tx_line == 1'b0, "R8", "line low after abort", tx_line, 0);
        lows = 0;
        sample_after_tick(b);
        while (!b && lows < 100) begin
            lows++;
            sample_after_tick(b);
        end
        check(lows == 22, "R9", "break bits", lows, 22);
        check(busy == 1'b1, "R10", "busy during mark", busy, 1);
        sample_after_tick(b);
        check(b == 1'b1 && busy == 1'b0, "R10", "idle after mark", {b, busy}, 2'b10);
        q.delete();

        // R8/R9 abort in start bit, no parity, 1 char -> 10 bits
        par_en = 1'b0;
        brk_chars = 4'd1;
        send(8'h00, "R8");
        @(negedge clk);
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        check(tx_line == 1'b0, "R8", "line low after abort", tx_line, 0);
        lows = 0;
        sample_after_tick(b);
        while (!b && lows < 100) begin
            lows++;
            sample_after_tick(b);
        end
        check(lows == 10, "R9", "break bits", lows, 10);
        wait_ticks(2);
        q.delete();
        mon_en = 1;

        // R8 dropped character not resent; normal data resumes
        send(8'h96, "R8");
        drain();

        // R11 abort while idle
        @(negedge clk);
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        sample_after_tick(b);
        check(b == 1'b1 && busy == 1'b0, "R11", "idle abort", {b, busy}, 2'b10);
        sample_after_tick(b);
        check(b == 1'b1, "R11", "line stays high", b, 1);
        check(q.size() == 0, "R8", "no leftover items", q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule